// File: doc/BRIEF.md
# Bit-serial dot product unit

The unit forms the signed inner product of a group of sixteen neuron values and sixteen synapse weights. It takes neuron values one bit at a time, with one wire per neuron, and takes the weights as full parallel words. In every cycle each weight word is passed through or forced to zero by the current bit of its neuron. The sixteen gated words are reduced by an adder tree. The tree output is folded into a running partial sum that doubles each cycle. Because the neuron bits arrive most significant first, the work for a p-bit neuron group takes exactly p cycles. The runtime precision p can be any value from 1 to 16, so a layer with narrow neurons finishes in proportionally fewer cycles.

An operation begins with a start pulse that carries the sign bit of every neuron and the precision of the group. The last bit cycle writes the finished sum into a result register, and a done pulse follows. A chain flag given with the start pulse adds the new group onto the held result. Successive groups of one window therefore build a single output. Without the flag, the new group replaces the held result. Neurons are two's complement, so the first bit of each operation carries negative weight.

Top module: `serial_dot_unit`

## Requirements
- R1: After reset, `result_o` is zero and `done_o` is low.
- R2: When `chain_i` is low with the start, the result is the signed sum over all lanes of neuron × weight, modulo 2^32. Each neuron is a p-bit two's complement number whose bits arrive on `nbit_i` most significant (sign) bit first, starting in the start cycle. Each weight is the 16-bit two's complement word at bits [16l+15:16l] of `syn_i` for lane l.
- R3: Any precision from 1 to 16 is accepted with `start_i`. `done_o` is high in the cycle that follows the p-th bit cycle, and low in the p−1 cycles before it.
- R4: When `chain_i` is high in the start cycle, the new result equals the previously held result plus the new inner product, modulo 2^32.
- R5: When `chain_i` is low in the start cycle, the previously held result has no influence on the new result.
- R6: A start pulse while an operation is running abandons that operation and begins a new one. The abandoned operation never changes `result_o` and never raises `done_o`.
- R7: While no operation is running, `nbit_i`, `syn_i`, `chain_i` and `prec_i` have no effect, and `result_o` holds its value and only changes in a cycle where `done_o` rises with it.
- R8: A lane whose current neuron bit is 0 adds nothing. A group whose neurons are all zero leaves a chained result unchanged.
- R9: The precision and the chain flag are sampled only in the start cycle. Changing `prec_i` or `chain_i` during the remaining bit cycles does not alter the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Marks the first (sign) bit cycle of an operation |
| chain_i | input | 1 | With start: add onto the held result instead of replacing it |
| prec_i | input | 5 | Neuron precision p, 1 to 16, sampled with start |
| nbit_i | input | 16 | Current serial bit of each neuron, one bit per lane |
| syn_i | input | 256 | Sixteen 16-bit two's complement weights, lane l at bits [16l+15:16l] |
| result_o | output | 32 | Held inner product result |
| done_o | output | 1 | One-cycle pulse after the last bit cycle, result valid |

## Verification
The assertions assume that `prec_i` lies between 1 and 16 whenever `start_i` is high. They also assume that the weights on `syn_i` stay fixed across the bit cycles of one operation. The bench drives a legal precision on every start pulse. Between start pulses it scrambles `prec_i` only to other legal values, and it holds each lane's weight steady until the operation ends. It drives arbitrary data only while the unit is idle, where the inputs are defined to be ignored.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
   localparam int SDU_LANES  = 16;
   localparam int SDU_WGT_W  = 16;
   localparam int SDU_MAX_P  = 16;
   localparam int SDU_ACC_W  = 32;

   // width needed to add LANES signed words of width w without overflow
   function automatic int tree_width(input int w, input int lanes);
      return w + $clog2(lanes);
   endfunction
endpackage

// File: rtl/sdu_gate.sv
module sdu_gate #(
   parameter int LANES = 16,
   parameter int WGT_W = 16
) (
   input  logic [LANES-1:0]       bit_i,
   input  logic [LANES*WGT_W-1:0] wgt_i,
   output logic [LANES*WGT_W-1:0] gated_o
);
   // one AND row per lane stands in for a multiplier
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign gated_o[l*WGT_W +: WGT_W] = wgt_i[l*WGT_W +: WGT_W] & {WGT_W{bit_i[l]}};
   end
endmodule

// File: rtl/sdu_tree.sv
module sdu_tree #(
   parameter int LANES  = 16,
   parameter int WGT_W  = 16,
   parameter int TREE_W = 20
) (
   input  logic [LANES*WGT_W-1:0]    word_i,
   output logic signed [TREE_W-1:0]  sum_o
);
   localparam int NODES = 2*LANES - 1;

   initial begin
      assert (LANES >= 2) else $error("sdu_tree: LANES must be at least 2");
      assert (TREE_W >= WGT_W + $clog2(LANES)) else $error("sdu_tree: TREE_W too narrow");
   end

   logic signed [TREE_W-1:0] node [NODES];

   // leaves sit at the back of the heap-ordered array
   for (genvar l = 0; l < LANES; l++) begin : g_leaf
      assign node[LANES-1+l] = {{(TREE_W-WGT_W){word_i[l*WGT_W+WGT_W-1]}},
                                word_i[l*WGT_W +: WGT_W]};
   end

   // each inner node adds its two children
   for (genvar i = 0; i < LANES-1; i++) begin : g_node
      assign node[i] = node[2*i+1] + node[2*i+2];
   end

   assign sum_o = node[0];
endmodule

// File: rtl/sdu_seq.sv
module sdu_seq #(
   parameter int MAX_P = 16,
   parameter int PW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [PW-1:0] prec_i,
   output logic          first_o,
   output logic          last_o,
   output logic          active_o
);
   logic          busy_q;
   logic [PW-1:0] left_q;   // bit cycles still to come, counting the current one

   initial begin
      assert (MAX_P >= 1) else $error("sdu_seq: MAX_P must be positive");
      assert (PW >= $clog2(MAX_P+1)) else $error("sdu_seq: PW too narrow");
   end

   assign first_o  = start_i;
   assign active_o = start_i | busy_q;
   assign last_o   = start_i ? (prec_i == PW'(1)) : (busy_q && left_q == PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start_i) begin
         busy_q <= (prec_i != PW'(1));
         left_q <= prec_i - PW'(1);
      end else if (busy_q) begin
         if (left_q == PW'(1)) busy_q <= 1'b0;
         left_q <= left_q - PW'(1);
      end
   end

   // R3
   prec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> (prec_i != '0 && prec_i <= PW'(MAX_P)));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !start_i && left_q > PW'(1)) |=> (busy_q && left_q == $past(left_q) - PW'(1)));
endmodule

// File: rtl/serial_dot_unit.sv
module serial_dot_unit
   import sdu_pkg::*;
#(
   parameter int LANES = SDU_LANES,
   parameter int WGT_W = SDU_WGT_W,
   parameter int MAX_P = SDU_MAX_P,
   parameter int ACC_W = SDU_ACC_W,
   localparam int PW     = $clog2(MAX_P+1),
   localparam int TREE_W = tree_width(WGT_W, LANES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic                   chain_i,
   input  logic [PW-1:0]          prec_i,
   input  logic [LANES-1:0]       nbit_i,
   input  logic [LANES*WGT_W-1:0] syn_i,
   output logic [ACC_W-1:0]       result_o,
   output logic                   done_o
);
   initial begin
      assert (ACC_W >= TREE_W) else $error("serial_dot_unit: ACC_W narrower than tree sum");
      assert (MAX_P <= ACC_W) else $error("serial_dot_unit: MAX_P exceeds ACC_W");
   end

   logic                     first, last, active;
   logic [LANES*WGT_W-1:0]   gated;
   logic signed [TREE_W-1:0] tree_sum;
   logic [ACC_W-1:0]         tree_ext, part_q, part_nxt, base, res_q;
   logic                     chain_q, chain_sel, done_q;

   sdu_seq #(.MAX_P(MAX_P), .PW(PW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec_i(prec_i),
      .first_o(first), .last_o(last), .active_o(active)
   );

   sdu_gate #(.LANES(LANES), .WGT_W(WGT_W)) u_gate (
      .bit_i(nbit_i), .wgt_i(syn_i), .gated_o(gated)
   );

   sdu_tree #(.LANES(LANES), .WGT_W(WGT_W), .TREE_W(TREE_W)) u_tree (
      .word_i(gated), .sum_o(tree_sum)
   );

   assign tree_ext = {{(ACC_W-TREE_W){tree_sum[TREE_W-1]}}, tree_sum};

   // sign bit carries negative weight; later bits double what came before
   assign part_nxt  = first ? (ACC_W'(0) - tree_ext) : ((part_q << 1) + tree_ext);
   assign chain_sel = first ? chain_i : chain_q;
   assign base      = chain_sel ? res_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q  <= '0;
         chain_q <= 1'b0;
         res_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (active) part_q <= part_nxt;
         if (first) chain_q <= chain_i;
         if (last) res_q <= base + part_nxt;
      end
   end

   assign result_o = res_q;
   assign done_o   = done_q;

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   // R8
   gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nbit_i == '0) |-> (tree_sum == '0));
endmodule

// File: tb/serial_dot_unit_tb.sv
`timescale 1ns/1ps
module serial_dot_unit_tb;
   localparam int N  = 16;
   localparam int W  = 16;
   localparam int A  = 32;
   localparam int PW = 5;
   localparam int NV = 12;

   // stimulus table: precision, chain flag, data seed
   localparam int V_PREC  [NV] = '{3, 16, 1, 7, 9, 2, 13, 5, 10, 4, 11, 6};
   localparam int V_CHAIN [NV] = '{0, 0, 1, 1, 0, 1, 0, 1, 1, 0, 1, 0};
   localparam int V_SEED  [NV] = '{11, 29, 7, 101, 77, 5, 1234, 999, 42, 3141, 2718, 65};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic chain = 1'b0;
   logic [PW-1:0]  prec = '0;
   logic [N-1:0]   nbit = '0;
   logic [N*W-1:0] syn = '0;
   logic [A-1:0]   result;
   logic           done;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   int nval [N];
   int wval [N];
   logic [31:0] exp_res = '0;
   int unsigned rng = 1;

   always #2.5 clk = ~clk;

   serial_dot_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .chain_i(chain), .prec_i(prec),
      .nbit_i(nbit), .syn_i(syn), .result_o(result), .done_o(done)
   );

   function automatic int unsigned nxt();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill(input int p);
      for (int l = 0; l < N; l++) begin
         logic [31:0] r;
         int v;
         r = nxt();
         v = int'(r & ((32'd1 << p) - 1));
         if (v >= (1 << (p-1))) v -= (1 << p);
         nval[l] = v;
         r = nxt();
         wval[l] = int'($signed(r[15:0]));
      end
   endtask

   function automatic logic [31:0] dot();
      longint s = 0;
      for (int l = 0; l < N; l++) s += longint'(nval[l]) * longint'(wval[l]);
      return s[31:0];
   endfunction

   // drives one operation MSB first and checks done timing and the result
   task automatic run_op(input int p, input bit ch, input string req);
      logic [31:0] e;
      bit early = 1'b0;
      e = (ch ? exp_res : 32'd0) + dot();
      for (int k = 0; k < p; k++) begin
         @(negedge clk);
         if (k > 0 && done) early = 1'b1;
         start = (k == 0);
         chain = (k == 0) ? ch : ~ch;                      // R9 scramble
         prec  = (k == 0) ? PW'(p) : PW'(((p + k) % 16) + 1);
         for (int l = 0; l < N; l++) begin
            nbit[l] = nval[l][p-1-k];
            syn[l*W +: W] = wval[l][15:0];
         end
      end
      @(negedge clk);
      start = 1'b0;
      chain = 1'b0;
      nbit  = '0;
      chk(!early, {req, " R3 done before last bit"}, 32'(early), 32'd0);
      chk(done == 1'b1, {req, " R3 done after p cycles"}, 32'(done), 32'd1);
      chk(result == e, {req, " result R9"}, result, e);
      exp_res = e;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(result == '0, "R1 result after reset", result, 32'd0);
      chk(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(result == '0 && done == 1'b0, "R1 idle after release", result, 32'd0);

      // table walk: R2 / R4 / R5 over many precisions
      for (int i = 0; i < NV; i++) begin
         rng = V_SEED[i];
         fill(V_PREC[i]);
         run_op(V_PREC[i], V_CHAIN[i] != 0, V_CHAIN[i] != 0 ? "R4 chained" : "R5 R2 fresh");
      end

      // R2 extremes at p=1: every neuron -1, every weight most negative
      for (int l = 0; l < N; l++) begin nval[l] = -1; wval[l] = -32768; end
      run_op(1, 1'b0, "R2 p1 extreme");
      chk(exp_res == 32'd524288, "R2 p1 extreme value", exp_res, 32'd524288);

      // R2 extremes at p=16 wrap modulo 2^32 to zero
      for (int l = 0; l < N; l++) begin nval[l] = -32768; wval[l] = -32768; end
      run_op(16, 1'b0, "R2 p16 wrap");

      // back-to-back single-bit operations
      rng = 555; fill(1); run_op(1, 1'b1, "R4 p1 back to back a");
      rng = 556; fill(1); run_op(1, 1'b1, "R4 p1 back to back b");

      // R8 all-zero neurons leave a chained result unchanged
      rng = 808; fill(9);
      for (int l = 0; l < N; l++) nval[l] = 0;
      begin
         logic [31:0] keep;
         keep = exp_res;
         run_op(9, 1'b1, "R8 zero neurons");
         chk(result == keep, "R8 held value kept", result, keep);
      end

      // R6 abandon a running operation with a new start
      rng = 321; fill(8);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         start = (k == 0);
         chain = 1'b0;
         prec  = PW'(8);
         for (int l = 0; l < N; l++) begin
            nbit[l] = nval[l][7-k];
            syn[l*W +: W] = wval[l][15:0];
         end
      end
      chk(done == 1'b0, "R6 no done from abandoned op", 32'(done), 32'd0);
      chk(result == exp_res, "R6 abandoned op leaves result", result, exp_res);
      rng = 654; fill(5);
      run_op(5, 1'b1, "R6 restart chained");

      // R7 idle inputs ignored
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         start = 1'b0;
         nbit  = N'(nxt());
         syn   = {8{nxt()}};
         chain = nxt() % 2 == 1;
         prec  = PW'(nxt() % 16 + 1);
      end
      @(negedge clk);
      chk(done == 1'b0, "R7 idle done", 32'(done), 32'd0);
      chk(result == exp_res, "R7 idle result held", result, exp_res);

      // R5 after idle: fresh op ignores held value
      nbit = '0;
      rng = 4242; fill(12);
      run_op(12, 1'b0, "R5 fresh after idle");

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule